// File: doc/BRIEF.md
# Hashed Page Table Walker

This block translates a 32-bit effective address into a real page number by walking a hashed page table held in memory. The top four address bits pick one of sixteen segment descriptors, supplied as one flat vector. A descriptor can mark its segment as direct-store, or as closed to instruction fetch. If the segment is neither, the walker builds a primary hash from the segment's virtual ID and the page index. From that hash and the table configuration word it forms a 64-byte group address. It then reads the group's eight two-word entries through a simple request/acknowledge memory port.

Each matching entry is checked against a protection key and the entry's two page-protection bits. When several entries in a group match, they must agree. If the primary group gives no grant, the secondary group, formed from the complemented hash, is searched. The walker keeps the referenced and changed bits of the chosen entry up to date by writing the entry's second word back, but only when that word actually changes. The result is a status code, the real page number and the read and write permissions. These are held until the next request completes and are marked by a one-cycle done pulse.

Top module: `hpt_walker`

## Requirements
- R1: A descriptor with bit 31 set (selected by address bits 31:28) ends the request with status 4 (direct-store), with no memory access.
- R2: An instruction fetch through a descriptor with bit 28 set ends with status 3 (no-execute) and no memory access. A data access through the same descriptor walks the table.
- R3: The primary group address is cfg[31:16]<<16 OR (((vsid XOR page) AND 0x7FFFF)<<6 AND ({cfg[8:0],0xFFC0})), where vsid is descriptor bits 23:0 and page is address bits 27:12. Entry i is at group+8i (word 0) and group+8i+4 (word 1). Word 1 is read only when word 0 matches: bit 31 set, bit 6 equal to the group select (0 primary, 1 secondary), and the other bits equal to (vsid<<7)|(page>>10).
- R4: The key is 1 when (descriptor bit 29 and user mode) or (descriptor bit 30 and supervisor mode). With key 0, read is always allowed and write is allowed unless the protection bits (word 1 bits 1:0) are 11. With key 1, 00 allows nothing, 01 and 11 allow read only, and 10 allows read and write.
- R5: The secondary group (hash = NOT primary hash AND 0x01FFFFC0) is searched only when the primary group grants nothing. Its result replaces the primary one only when it contains a match.
- R6: Two matching entries in one group whose word 1 differs under mask 0xFFFFF07B make that group "not found", with no write-back.
- R7: The chosen entry's word 1 gets bit 8 (referenced) set. Word 1 is written back once, only when it changed, and the written word always has bit 8 set.
- R8: Bit 7 (changed) is set on a granted write. While bit 7 stays clear, the write permission output is 0.
- R9: Status codes are 0 hit, 1 not found, 2 protection violation, 3 no-execute, 4 direct-store. done is a single-cycle pulse, busy is high during a walk, and a request raised while busy is ignored.
- R10: A memory request holds its address, write enable and data until acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Start a translation (taken only when idle) |
| req_ea | input | 32 | Effective address |
| req_write | input | 1 | Access is a store |
| req_fetch | input | 1 | Access is an instruction fetch |
| req_user | input | 1 | Access is made in user mode |
| seg_file | input | 512 | Sixteen 32-bit segment descriptors, descriptor n at bits 32n+31:32n |
| table_cfg | input | 32 | Table base (bits 31:16) and hash mask extension (bits 8:0) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access completed; read data valid |
| mem_rdata | input | 32 | Read data |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Result code |
| rpn | output | 20 | Real page number |
| perm_rd | output | 1 | Read allowed |
| perm_wr | output | 1 | Write allowed |

## Verification
The referenced-bit update and the changed-bit update can both fall on the same write-back. This is provoked with a granted store to an entry that has bits 8 and 7 both clear. The memory model must then see exactly one write, carrying both bits set, and the store must be granted with write permission. A second collision is a request arriving while a walk is busy. It is provoked with a request to a direct-store segment in the middle of a walk. The check passes only if a single done pulse carries the hit of the first walk.

// File: rtl/hpt_walker.sv
module hpt_walker (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req_valid,
  input  logic [31:0]  req_ea,
  input  logic         req_write,
  input  logic         req_fetch,
  input  logic         req_user,
  input  logic [511:0] seg_file,
  input  logic [31:0]  table_cfg,
  output logic         mem_req,
  output logic         mem_we,
  output logic [31:0]  mem_addr,
  output logic [31:0]  mem_wdata,
  input  logic         mem_ack,
  input  logic [31:0]  mem_rdata,
  output logic         busy,
  output logic         done,
  output logic [2:0]   status,
  output logic [19:0]  rpn,
  output logic         perm_rd,
  output logic         perm_wr
);
  typedef enum logic [2:0] {S_IDLE, S_W0, S_W1, S_FIN, S_WB, S_NX} st_t;
  localparam logic [1:0] G_NONE = 2'd0, G_OK = 2'd1, G_DENY = 2'd2;
  localparam logic [2:0] ST_HIT = 3'd0, ST_MISS = 3'd1, ST_PROT = 3'd2,
                         ST_NOEX = 3'd3, ST_DIRECT = 3'd4;

  st_t st;
  logic sec, key, wr, good, fin_q, gacc_r, gacc_w;
  logic [1:0] gret;
  logic [2:0] idx, kidx;
  logic [31:0] base, base_s, keep;
  logic [30:0] ptem;
  logic [2:0] res_st;
  logic [19:0] res_rpn;
  logic res_rd, res_wr, done_q;

  logic [31:0] seg;
  logic [24:0] hp, hs, hmask;
  assign seg   = seg_file[req_ea[31:28]*32 +: 32];
  assign hp    = {seg[18:0] ^ {3'b000, req_ea[27:12]}, 6'b0};
  assign hs    = ~hp & 25'h1FFFFC0;
  assign hmask = {table_cfg[8:0], 16'hFFC0};

  logic w0hit, acc_r, acc_w, grant, conflict, store;
  logic [1:0] pp;
  logic [31:0] newkeep;
  assign w0hit = mem_rdata[31] && (mem_rdata[6] == sec) &&
                 ({mem_rdata[30:7], 1'b0, mem_rdata[5:0]} == ptem);
  assign pp    = mem_rdata[1:0];
  assign acc_r = key ? (pp != 2'b00) : 1'b1;
  assign acc_w = key ? (pp == 2'b10) : (pp != 2'b11);
  assign grant = wr ? acc_w : acc_r;
  assign conflict = good && (((keep ^ mem_rdata) & 32'hFFFFF07B) != 32'h0);
  assign newkeep  = keep | 32'h100 |
                    ((wr && gret == G_OK && !keep[7]) ? 32'h80 : 32'h0);
  assign store    = good && (newkeep != keep);

  logic unused_bits;
  assign unused_bits = ^{req_ea[11:0], seg[27:24], table_cfg[15:9], base[5:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sec <= 1'b0; key <= 1'b0; wr <= 1'b0; good <= 1'b0;
      fin_q <= 1'b0; gacc_r <= 1'b0; gacc_w <= 1'b0; gret <= G_NONE;
      idx <= '0; kidx <= '0; base <= '0; base_s <= '0; keep <= '0;
      ptem <= '0; res_st <= ST_HIT; res_rpn <= '0; res_rd <= 1'b0;
      res_wr <= 1'b0; done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          wr  <= req_write;
          key <= (seg[29] && req_user) || (seg[30] && !req_user);
          if (seg[31] || (req_fetch && seg[28])) begin
            res_st  <= seg[31] ? ST_DIRECT : ST_NOEX;
            res_rpn <= '0; res_rd <= 1'b0; res_wr <= 1'b0;
            done_q  <= 1'b1;
          end else begin
            base   <= {table_cfg[31:16], 16'h0} | {7'b0, hp & hmask};
            base_s <= {table_cfg[31:16], 16'h0} | {7'b0, hs & hmask};
            ptem   <= {seg[23:0], 7'b0} | {25'b0, req_ea[27:22]};
            sec <= 1'b0; idx <= '0; good <= 1'b0; gret <= G_NONE;
            gacc_r <= 1'b0; gacc_w <= 1'b0;
            st <= S_W0;
          end
        end
        S_W0: if (mem_ack) begin
          if (w0hit) st <= S_W1;
          else if (idx == 3'd7) st <= S_FIN;
          else idx <= idx + 3'd1;
        end
        S_W1: if (mem_ack) begin
          if (conflict) begin
            good <= 1'b0; gret <= G_NONE; gacc_r <= 1'b0; gacc_w <= 1'b0;
            st <= S_FIN;
          end else begin
            if (!good) begin
              good <= 1'b1; keep <= mem_rdata; kidx <= idx;
            end
            if (gret != G_OK) begin
              gacc_r <= acc_r; gacc_w <= acc_w;
              if (grant) begin
                gret <= G_OK; keep <= mem_rdata; kidx <= idx;
              end else gret <= G_DENY;
            end
            if (idx == 3'd7) st <= S_FIN;
            else begin idx <= idx + 3'd1; st <= S_W0; end
          end
        end
        S_FIN: begin
          if (!sec || gret != G_NONE) begin
            res_st  <= !good ? ST_MISS : (gret == G_OK ? ST_HIT : ST_PROT);
            res_rpn <= good ? keep[31:12] : 20'h0;
            res_rd  <= good && gacc_r;
            res_wr  <= good && gacc_w && newkeep[7];
          end
          fin_q <= sec || gret == G_OK;
          keep  <= newkeep;
          st    <= store ? S_WB : S_NX;
        end
        S_WB: if (mem_ack) st <= S_NX;
        S_NX: if (fin_q) begin
          st <= S_IDLE; done_q <= 1'b1;
        end else begin
          sec <= 1'b1; base <= base_s; idx <= '0; good <= 1'b0;
          gret <= G_NONE; gacc_r <= 1'b0; gacc_w <= 1'b0; st <= S_W0;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req   = (st == S_W0) || (st == S_W1) || (st == S_WB);
  assign mem_we    = (st == S_WB);
  assign mem_wdata = keep;
  always_comb begin
    case (st)
      S_W1:    mem_addr = {base[31:6], idx, 3'b100};
      S_WB:    mem_addr = {base[31:6], kidx, 3'b100};
      default: mem_addr = {base[31:6], idx, 3'b000};
    endcase
  end

  assign busy    = (st != S_IDLE);
  assign done    = done_q;
  assign status  = res_st;
  assign rpn     = res_rpn;
  assign perm_rd = res_rd;
  assign perm_wr = res_wr;

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_req);
  p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                            && $stable(mem_wdata));
  p_wb_ref_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_wdata[8] && mem_addr[2]);
  p_hit_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done && status == ST_HIT |-> perm_rd);
  p_status_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> status <= ST_DIRECT);
endmodule

// File: tb/sim_hpt_walker.sv
module sim_hpt_walker;
  localparam int CLK_NS = 10;
  localparam logic [31:0] CFG = 32'h0001_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_fetch = 1'b0, req_user = 1'b0;
  logic [31:0] req_ea = '0;
  logic [511:0] seg_file;
  logic [31:0] segs [16];
  logic mem_req, mem_we, mem_ack = 1'b0, busy, done, perm_rd, perm_wr;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [2:0] status;
  logic [19:0] rpn;

  int vectors = 0, miscompares = 0, rd_cnt = 0, wr_cnt = 0, done_cnt = 0;
  logic [31:0] mem [logic [31:0]];

  always #(CLK_NS/2) clk = ~clk;

  always_comb for (int i = 0; i < 16; i++) seg_file[i*32 +: 32] = segs[i];

  hpt_walker u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ea(req_ea),
    .req_write(req_write), .req_fetch(req_fetch), .req_user(req_user),
    .seg_file(seg_file), .table_cfg(CFG), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .status(status), .rpn(rpn),
    .perm_rd(perm_rd), .perm_wr(perm_wr));

  always @(posedge clk) begin
    if (done) done_cnt++;
    if (mem_req && !mem_ack) begin
      mem_ack <= 1'b1;
      mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
      if (mem_we) begin mem[mem_addr] = mem_wdata; wr_cnt++; end
      else rd_cnt++;
    end else mem_ack <= 1'b0;
  end

  function automatic logic [31:0] grp(input logic [23:0] v, input logic [15:0] p,
                                      input logic s);
    logic [24:0] h;
    h = {v[18:0] ^ {3'b000, p}, 6'b0};
    if (s) h = ~h & 25'h1FFFFC0;
    return {CFG[31:16], 16'h0} | {7'b0, h & {CFG[8:0], 16'hFFC0}};
  endfunction

  function automatic logic [31:0] w0(input logic [23:0] v, input logic [15:0] p,
                                     input logic s);
    return {1'b1, v, s, p[15:10]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] ea, input logic w, input logic f, input logic u);
    int cyc;
    @(negedge clk);
    rd_cnt = 0; wr_cnt = 0;
    req_ea = ea; req_write = w; req_fetch = f; req_user = u; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!done && cyc < 2000) begin @(negedge clk); cyc++; end
    if (!done) chk("R9 done timeout", 0, 1);
  endtask

  task automatic t_reset;
    chk("R9 reset busy", busy, 0);
    chk("R9 reset done", done, 0);
    chk("R10 reset mem_req", mem_req, 0);
  endtask

  task automatic t_direct;
    mem.delete();
    segs[13] = 32'h8000_0000;
    run(32'hD000_0000, 0, 0, 0);
    chk("R1 direct status", status, 4);
    chk("R1 direct no memory", rd_cnt + wr_cnt, 0);
  endtask

  task automatic t_noexec;
    mem.delete();
    segs[14] = 32'h1000_0456;
    run(32'hE000_1000, 0, 1, 0);
    chk("R2 no-exec status", status, 3);
    chk("R2 no-exec no memory", rd_cnt, 0);
    run(32'hE000_1000, 0, 0, 0);
    chk("R2 data access walks, not found", status, 1);
    chk("R5 both groups scanned", rd_cnt, 16);
  endtask

  task automatic t_hit_read;
    logic [31:0] g;
    mem.delete();
    segs[1] = 32'h0000_0123;
    g = grp(24'h123, 16'h0045, 0);
    mem[g + 24] = w0(24'h123, 16'h0045, 0);
    mem[g + 28] = 32'hABCDE002;
    run(32'h1004_5000, 0, 0, 0);
    chk("R3 hit status", status, 0);
    chk("R3 rpn", rpn, 20'hABCDE);
    chk("R3 reads primary only", rd_cnt, 9);
    chk("R8 write withheld while C clear", perm_wr, 0);
    chk("R4 key0 read", perm_rd, 1);
    chk("R7 one write-back", wr_cnt, 1);
    chk("R7 referenced set", mem[g + 28], 32'hABCDE102);
    run(32'h1004_5000, 0, 0, 0);
    chk("R7 no write-back when unchanged", wr_cnt, 0);
  endtask

  task automatic t_write_rc;
    logic [31:0] g;
    mem.delete();
    g = grp(24'h123, 16'h0045, 0);
    mem[g] = w0(24'h123, 16'h0045, 0);
    mem[g + 4] = 32'h12345002;
    run(32'h1004_5000, 1, 0, 0);
    chk("R8 write hit", status, 0);
    chk("R8 write permitted", perm_wr, 1);
    chk("R7 single write-back", wr_cnt, 1);
    chk("R8 R and C set together", mem[g + 4], 32'h12345182);
  endtask

  task automatic t_key;
    logic [31:0] g;
    mem.delete();
    segs[2] = 32'h2000_0777;
    g = grp(24'h777, 16'h0003, 0);
    mem[g] = w0(24'h777, 16'h0003, 0);
    mem[g + 4] = 32'h55555101;
    run(32'h2000_3000, 0, 0, 1);
    chk("R4 key1 pp01 read hit", status, 0);
    chk("R4 key1 pp01 no write perm", perm_wr, 0);
    chk("R7 no store when R already set", wr_cnt, 0);
    run(32'h2000_3000, 1, 0, 1);
    chk("R4 key1 pp01 write denied", status, 2);
    chk("R5 secondary searched after deny", rd_cnt, 17);
    chk("R5 deny not written back", wr_cnt, 0);
    run(32'h2000_3000, 1, 0, 0);
    chk("R4 key0 pp01 write allowed", status, 0);
    chk("R8 C set on granted write", mem[g + 4], 32'h55555181);
    mem[g + 4] = 32'h55555180;
    run(32'h2000_3000, 0, 0, 1);
    chk("R4 key1 pp00 read denied", status, 2);
  endtask

  task automatic t_secondary;
    logic [31:0] gp, gs;
    mem.delete();
    segs[3] = 32'h0000_0ABC;
    gp = grp(24'hABC, 16'h1234, 0);
    gs = grp(24'hABC, 16'h1234, 1);
    mem[gp] = w0(24'hABC, 16'h1234, 1);
    mem[gp + 4] = 32'h99999182;
    mem[gs + 40] = w0(24'hABC, 16'h1234, 1);
    mem[gs + 44] = 32'h0F0F0182;
    run(32'h3123_4000, 0, 0, 0);
    chk("R5 secondary hit", status, 0);
    chk("R5 secondary rpn", rpn, 20'h0F0F0);
    chk("R3 select bit respected", rd_cnt, 17);
  endtask

  task automatic t_dup;
    logic [31:0] g;
    mem.delete();
    segs[4] = 32'h0000_0055;
    g = grp(24'h055, 16'h0007, 0);
    mem[g + 8]  = w0(24'h055, 16'h0007, 0);
    mem[g + 12] = 32'h11111182;
    mem[g + 48] = w0(24'h055, 16'h0007, 0);
    mem[g + 52] = 32'h22222182;
    run(32'h4000_7000, 0, 0, 0);
    chk("R6 disagreeing duplicates not found", status, 1);
    chk("R6 no write-back", wr_cnt, 0);
    mem[g + 52] = 32'h11111082;
    run(32'h4000_7000, 0, 0, 0);
    chk("R6 agreeing duplicates hit", status, 0);
    chk("R6 rpn from duplicates", rpn, 20'h11111);
  endtask

  task automatic t_busy;
    logic [31:0] g;
    int d0;
    mem.delete();
    g = grp(24'h123, 16'h0045, 0);
    mem[g + 24] = w0(24'h123, 16'h0045, 0);
    mem[g + 28] = 32'hABCDE182;
    @(negedge clk);
    d0 = done_cnt;
    req_ea = 32'h1004_5000; req_write = 0; req_fetch = 0; req_user = 0; req_valid = 1;
    @(negedge clk); req_valid = 0;
    repeat (3) @(negedge clk);
    chk("R9 busy during walk", busy, 1);
    req_ea = 32'hD000_0000; req_valid = 1;
    @(negedge clk); req_valid = 0;
    repeat (60) @(negedge clk);
    chk("R9 request while busy ignored", done_cnt - d0, 1);
    chk("R9 first walk result kept", status, 0);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) segs[i] = 32'h0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_direct;
    t_noexec;
    t_hit_read;
    t_write_rc;
    t_key;
    t_secondary;
    t_dup;
    t_busy;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #(CLK_NS * 150000);
    miscompares++;
    $display("FAIL R9 watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule